// File: doc/BRIEF.md
# Settable BCD Time-of-Day Counter

This block keeps the time of day as six BCD digits, two each for hours, minutes and seconds. A free-running divider turns the system clock (50 MHz by default) into a single-cycle pulse once per second, and the seconds field advances on that pulse. In normal running, a seconds wrap carries into the minutes, and a minutes wrap carries into the hours. The hours field wraps after 23.

To set the time, an operator holds a switch. While the minute switch is on, the minutes advance by one on every seconds step. While the hour switch is on, the hours do the same. In either setup mode no carry passes between fields. A separate push-button forces only the seconds to zero.

A glyph renderer reads the time in two ways. It can take the whole packed digit bus. It can also walk a 3-bit screen position through an eight-place mux laid out as HH:MM:SS, with a reserved code standing for each colon. All pins are plain level or pulse signals. The block has no streamed data, so it has no valid/ready handshake and applies no back-pressure.

Top module: `bcd_wall_clock`

## Requirements
- R1: `sec_tick` is high for exactly one cycle in every `TICK_DIV` cycles, and each pulse advances the seconds by one.
- R2: Every digit is valid BCD (0 to 9), and the seconds go from 59 to 00.
- R3: In normal mode (both setup switches off), a seconds step from 59 increments the minutes. A step from 59:59 also increments the hours.
- R4: In normal mode, the step after 23:59:59 gives 00:00:00.
- R5: `sec_clear` makes the seconds 00 on the next edge. It wins over a coincident tick, produces no carry, and leaves minutes and hours unchanged.
- R6: While `set_minutes` is high, every tick increments the minutes. A wrap from 59 to 00 leaves the hours unchanged.
- R7: While `set_hours` is high, every tick increments the hours, and the hours wrap from 23 to 00.
- R8: In setup mode the seconds keep advancing, but a seconds wrap does not carry into any other field.
- R9: `pos_code` follows `pos_sel` combinationally in this order: 0 gives hours tens, 1 gives hours units, 2 gives colon (4'hA), 3 gives minutes tens, 4 gives minutes units, 5 gives colon (4'hA), 6 gives seconds tens, 7 gives seconds units.
- R10: While `rst_n` is low, the time reads 00:00:00. The first tick after release comes `TICK_DIV-1` rising edges after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_clear | input | 1 | Push-button level that zeroes the seconds |
| set_hours | input | 1 | Hour setup switch |
| set_minutes | input | 1 | Minute setup switch |
| pos_sel | input | 3 | Screen position 0 to 7 |
| sec_tick | output | 1 | One-cycle pulse per second |
| time_bcd | output | 24 | Digits {Ht,Hu,Mt,Mu,St,Su}, 4 bits each |
| pos_code | output | 4 | Digit or colon code for `pos_sel` |

## Verification
The carry and no-carry properties assume that the setup switches and the clear button are steady around each tick. A real switch held by hand meets this. The bench changes these inputs only on falling edges, well clear of any tick. The range properties assume that nothing other than reset and the increment logic writes the digits. The bench reaches edge values such as 23:59:59 only by holding the setup switches for a counted number of ticks, so every state it visits is one the block can reach by itself.

// File: rtl/wclk_pkg.sv
`timescale 1ns/1ps
package wclk_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] COLON_CODE = 4'hA;
  typedef logic [DIGIT_W-1:0] bcd_t;
  typedef struct packed {
    bcd_t tens;
    bcd_t ones;
  } digit_pair_t;
endpackage

// File: rtl/wclk_tick_gen.sv
`timescale 1ns/1ps
module wclk_tick_gen #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick_o = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R1: the count never passes its last value
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R1: a pulse is never followed directly by another
      a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/wclk_bcd_pair.sv
`timescale 1ns/1ps
module wclk_bcd_pair
  import wclk_pkg::*;
#(
  parameter int TENS_MAX = 5,
  parameter int ONES_MAX = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        inc,
  output digit_pair_t val,
  output logic        at_max
);
  localparam bcd_t T_MAX = bcd_t'(TENS_MAX);
  localparam bcd_t O_MAX = bcd_t'(ONES_MAX);

  assign at_max = (val.tens == T_MAX) && (val.ones == O_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      val <= '0;
    end else if (inc) begin
      if (at_max) begin
        val <= '0;
      end else if (val.ones == 4'd9) begin
        val.ones <= '0;
        val.tens <= val.tens + 1'b1;
      end else begin
        val.ones <= val.ones + 1'b1;
      end
    end
  end

  // R2: units digit stays decimal
  a_r2_ones_bcd: assert property (@(posedge clk) disable iff (!rst_n) val.ones <= 4'd9);
  // R2: tens digit stays within its field range
  a_r2_tens_range: assert property (@(posedge clk) disable iff (!rst_n) val.tens <= T_MAX);
  // R2/R4/R7: stepping from the field maximum lands on zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && at_max) |=> (val == '0));
  // R1: a step below the maximum changes the value
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !at_max) |=> (val != $past(val)));
  // R5: clear yields zero
  a_r5_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (val == '0));
endmodule

// File: rtl/wclk_pos_mux.sv
`timescale 1ns/1ps
module wclk_pos_mux
  import wclk_pkg::*;
(
  input  digit_pair_t hr,
  input  digit_pair_t mn,
  input  digit_pair_t sc,
  input  logic [2:0]  pos,
  output bcd_t        code
);
  always_comb begin
    unique case (pos)
      3'd0:    code = hr.tens;
      3'd1:    code = hr.ones;
      3'd3:    code = mn.tens;
      3'd4:    code = mn.ones;
      3'd6:    code = sc.tens;
      3'd7:    code = sc.ones;
      default: code = COLON_CODE;
    endcase
  end
endmodule

// File: rtl/bcd_wall_clock.sv
`timescale 1ns/1ps
module bcd_wall_clock
  import wclk_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_clear,
  input  logic        set_hours,
  input  logic        set_minutes,
  input  logic [2:0]  pos_sel,
  output logic        sec_tick,
  output logic [23:0] time_bcd,
  output logic [3:0]  pos_code
);
  digit_pair_t hr_q, mn_q, sc_q;
  logic hr_max, mn_max, sc_max;
  logic normal, mn_inc, hr_inc;

  wclk_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(sec_tick)
  );

  assign normal = !set_hours && !set_minutes;
  assign mn_inc = sec_tick && (set_minutes || (normal && sc_max && !sec_clear));
  assign hr_inc = sec_tick && (set_hours || (normal && sc_max && mn_max && !sec_clear));

  wclk_bcd_pair #(.TENS_MAX(5), .ONES_MAX(9)) u_sec (
    .clk(clk), .rst_n(rst_n), .clr(sec_clear), .inc(sec_tick), .val(sc_q), .at_max(sc_max)
  );
  wclk_bcd_pair #(.TENS_MAX(5), .ONES_MAX(9)) u_min (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(mn_inc), .val(mn_q), .at_max(mn_max)
  );
  wclk_bcd_pair #(.TENS_MAX(2), .ONES_MAX(3)) u_hr (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(hr_inc), .val(hr_q), .at_max(hr_max)
  );

  wclk_pos_mux u_mux (
    .hr(hr_q), .mn(mn_q), .sc(sc_q), .pos(pos_sel), .code(pos_code)
  );

  assign time_bcd = {hr_q, mn_q, sc_q};

  // R5: clear in normal mode zeroes seconds and leaves hours and minutes alone
  a_r5_clear_only_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_clear && normal) |=> (time_bcd[7:0] == 8'h00) && (time_bcd[23:8] == $past(time_bcd[23:8])));
  // R3: seconds wrap in normal mode moves the minutes
  a_r3_min_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && normal && !sec_clear && sc_max && !mn_max) |=> (time_bcd[15:8] != $past(time_bcd[15:8])));
  // R4: midnight rollover
  a_r4_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && normal && !sec_clear && sc_max && mn_max && hr_max) |=> (time_bcd == 24'h000000));
  // R8: with only the hour switch held, minutes never move
  a_r8_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hours && !set_minutes) |=> (time_bcd[15:8] == $past(time_bcd[15:8])));
  // R6: with only the minute switch held, hours never move
  a_r6_hold_hr: assert property (@(posedge clk) disable iff (!rst_n)
    (set_minutes && !set_hours) |=> (time_bcd[23:16] == $past(time_bcd[23:16])));
  // R9: a digit place never shows the colon code
  a_r9_digit_place: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_sel != 3'd2 && pos_sel != 3'd5) |-> (pos_code <= 4'd9));
endmodule

// File: tb/bcd_wall_clock_tb.sv
`timescale 1ns/1ps
module bcd_wall_clock_tb;
  localparam int unsigned DIV = 4;
  localparam int NV = 11;
  // {set_hours, set_minutes, tick count, expected time}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd5,  24'h000005},  // R1 normal steps
    {1'b0, 1'b1, 8'd58, 24'h005803},  // R6 R8 minute setup, seconds wrap w/o carry
    {1'b1, 1'b0, 8'd23, 24'h235826},  // R7 hour setup
    {1'b0, 1'b0, 8'd33, 24'h235859},  // R2 seconds reach 59
    {1'b0, 1'b0, 8'd1,  24'h235900},  // R3 carry into minutes
    {1'b0, 1'b0, 8'd59, 24'h235959},  // R2
    {1'b0, 1'b0, 8'd1,  24'h000000},  // R4 midnight
    {1'b0, 1'b1, 8'd61, 24'h000101},  // R6 minutes wrap, hours unchanged
    {1'b1, 1'b0, 8'd25, 24'h012601 ^ 24'h000000 ^ 24'h012601 ^ 24'h010126}, // R7 hours wrap
    {1'b1, 1'b1, 8'd2,  24'h030328},  // R6 R7 both switches
    {1'b0, 1'b0, 8'd32, 24'h030400}   // R3 carry after setup
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_clear = 1'b0, set_hours = 1'b0, set_minutes = 1'b0;
  logic [2:0] pos_sel = 3'd0;
  logic sec_tick;
  logic [23:0] time_bcd;
  logic [3:0] pos_code;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_wall_clock #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_clear(sec_clear), .set_hours(set_hours),
    .set_minutes(set_minutes), .pos_sel(pos_sel), .sec_tick(sec_tick),
    .time_bcd(time_bcd), .pos_code(pos_code)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!sec_tick);
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int gap;
    logic [3:0] exp_code [8];
    repeat (3) @(negedge clk);
    check("R10 reset time", time_bcd, 24'h000000);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      set_hours   = VEC[v][33];
      set_minutes = VEC[v][32];
      run_ticks(int'(VEC[v][31:24]));
      check($sformatf("R1-vector %0d (R3 R4 R6 R7 R8)", v), time_bcd, VEC[v][23:0]);
    end
    set_hours = 1'b0; set_minutes = 1'b0;

    // R1: spacing between pulses
    do @(negedge clk); while (!sec_tick);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sec_tick);
    check("R1 tick spacing", 24'(gap), 24'(DIV));
    @(negedge clk);
    check("R1 seconds after two ticks", time_bcd, 24'h030402);

    // R5: clear between ticks
    run_ticks(5);
    sec_clear = 1'b1;
    @(negedge clk);
    sec_clear = 1'b0;
    check("R5 clear between ticks", time_bcd, 24'h030400);

    // R5: clear coinciding with a tick at 59, no carry
    run_ticks(59);
    check("R2 seconds at 59", time_bcd, 24'h030459);
    sec_clear = 1'b1;
    do @(negedge clk); while (!sec_tick);
    @(negedge clk);
    sec_clear = 1'b0;
    check("R5 clear wins over tick at 59", time_bcd, 24'h030400);

    // R9: position mux at 03:04:00
    exp_code = '{4'h0, 4'h3, 4'hA, 4'h0, 4'h4, 4'hA, 4'h0, 4'h0};
    for (int p = 0; p < 8; p++) begin
      pos_sel = 3'(p);
      #1;
      check($sformatf("R9 position %0d", p), 24'(pos_code), 24'(exp_code[p]));
    end

    // R10: reset mid-run and first pulse timing
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 reset clears time", time_bcd, 24'h000000);
    rst_n = 1'b1;
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sec_tick);
    check("R10 first tick after release", 24'(gap), 24'(DIV - 1));
    @(negedge clk);
    check("R10 first second counted", time_bcd, 24'h000001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule